// File: doc/BRIEF.md
# Request Crossbar Switch

This block is a one-way switch that carries transfer requests from a set of source ports to a set of destination ports. With the default parameters there are eight sources and nine destinations: eight cache banks plus one non-cacheable I/O unit. The return path uses the same module with the two counts swapped (nine sources, eight destinations). Each source offers a packet together with a destination index. Every source-destination pair has its own two-entry holding queue. Each destination runs its own round-robin arbiter over the pairs that hold work for it and sends at most one packet per cycle through a registered pipeline.

The source side is a valid/ready stream. A source raises `src_valid` and holds the packet and the destination index stable until a cycle in which `src_ready` is high. That cycle's rising edge completes the transfer. `src_ready` is the back-pressure credit for the pair named by the index being presented. It drops when that pair's queue is full. The destination side has no ready input: every destination always accepts what it is given, and `dst_valid` marks a packet for exactly one cycle.

Internally each packet passes through four registered stages. The pair queue is the request stage. The arbitration register holds the winning source and pops its queue. The selection register follows, and the transmit register drives the outputs.

Top module: `req_xbar`

## Requirements
- R1: After synchronous reset, every `dst_valid` bit is low and every pair queue is empty, so `src_ready` is high for any in-range destination index. Every arbiter pointer is at source 0, so the first contended grant goes to the lowest-numbered requester.
- R2: A packet is taken on a rising edge where `src_valid` and `src_ready` are both high. `src_ready` is low exactly when the pair queue for the presented index already holds two entries.
- R3: A pair queue never holds more than two entries. A source that meets back-pressure stalls, and no packet is lost or duplicated.
- R4: Without contention, a packet taken on edge k is presented on its destination's outputs in the cycle that follows edge k+3.
- R5: A packet appears only on the destination named by its index. `dst_src` carries the source number and `dst_data` equals the accepted `src_data`.
- R6: Distinct destinations each send a packet in the same cycle, even when the packets come from different sources. Eight source-to-destination streams run at full rate together.
- R7: A destination index of NDST or larger is never accepted. `src_ready` stays low and no output appears.
- R8: Each destination grants the first requesting source at or after its pointer, wrapping past the last source. The pointer then moves to the winner plus one. When every source is saturated on one destination, the output sources follow 0, 1, ... NSRC-1 in a repeating cycle.
- R9: Packets from one source to one destination leave in the order they were taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | NSRC | Per-source packet valid |
| src_ready | output | NSRC | Per-source credit for the presented pair |
| src_dst | input | NSRC*DIW | Per-source destination index, source s in bits [s*DIW +: DIW] |
| src_data | input | NSRC*DW | Per-source payload, source s in bits [s*DW +: DW] |
| dst_valid | output | NDST | Per-destination packet valid, one cycle per packet |
| dst_src | output | NDST*SIW | Source number of the packet on destination d, bits [d*SIW +: SIW] |
| dst_data | output | NDST*DW | Payload on destination d, bits [d*DW +: DW] |

## Verification
The assertions rely on sources following the stream rule: once `src_valid` is raised, the packet and index stay put until `src_ready` is seen high. The in-flight count per pair, taken from the ports, then holds at most two queued entries plus three pipeline registers. The bench driver respects this rule because it keeps each offer on the pins until the cycle it is taken. It only changes or withdraws an offer after an acceptance. The out-of-range index test drives illegal indices on purpose and holds them; the assertions expect exactly this case to be refused.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Step an index forward by one within 0..n-1.
  function automatic int idx_step(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // Add an offset to an index modulo n, for offsets below n.
  function automatic int idx_add(input int v, input int off, input int n);
    return (v + off >= n) ? v + off - n : v + off;
  endfunction

endpackage

// File: rtl/xbar_pair_q.sv
module xbar_pair_q #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] slot [2];
  logic          wr_sel;
  logic          rd_sel;
  logic [1:0]    fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sel <= 1'b0;
      rd_sel <= 1'b0;
      fill   <= 2'd0;
    end else begin
      if (push) begin
        slot[wr_sel] <= push_data;
        wr_sel       <= ~wr_sel;
      end
      if (pop) rd_sel <= ~rd_sel;
      fill <= fill + {1'b0, push} - {1'b0, pop};
    end
  end

  assign head  = slot[rd_sel];
  assign empty = (fill == 2'd0);
  assign full  = (fill == 2'd2);
endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb
  import xbar_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic          gnt_any,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int off = 0; off < N; off++) begin
      int cand;
      cand = idx_add(int'(ptr), off, N);
      if (!gnt_any && req[cand]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (gnt_any) ptr <= IW'(idx_step(int'(gnt_idx), N));
  end
endmodule

// File: rtl/xbar_dst_port.sv
module xbar_dst_port #(
  parameter int NSRC = 8,
  parameter int DW   = 16,
  localparam int SIW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    req,
  input  logic [NSRC*DW-1:0] heads,
  output logic [NSRC-1:0]    pop,
  output logic               out_valid,
  output logic [SIW-1:0]     out_src,
  output logic [DW-1:0]      out_data
);
  logic           win_any;
  logic [SIW-1:0] win_idx;

  // Stage registers: arbitration, selection (transmit drives the outputs).
  logic           arb_vld, sel_vld;
  logic [SIW-1:0] arb_src, sel_src;
  logic [DW-1:0]  arb_data, sel_data;

  xbar_rr_arb #(.N(NSRC)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .gnt_any (win_any),
    .gnt_idx (win_idx)
  );

  always_comb begin
    pop = '0;
    if (win_any) pop[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arb_vld   <= 1'b0;
      sel_vld   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      arb_vld   <= win_any;
      sel_vld   <= arb_vld;
      out_valid <= sel_vld;
    end
    arb_src  <= win_idx;
    arb_data <= heads[win_idx*DW +: DW];
    sel_src  <= arb_src;
    sel_data <= arb_data;
    out_src  <= sel_src;
    out_data <= sel_data;
  end
endmodule

// File: rtl/req_xbar.sv
module req_xbar #(
  parameter int NSRC = 8,
  parameter int NDST = 9,
  parameter int DW   = 16,
  localparam int DIW = (NDST > 1) ? $clog2(NDST) : 1,
  localparam int SIW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC-1:0]     src_valid,
  output logic [NSRC-1:0]     src_ready,
  input  logic [NSRC*DIW-1:0] src_dst,
  input  logic [NSRC*DW-1:0]  src_data,
  output logic [NDST-1:0]     dst_valid,
  output logic [NDST*SIW-1:0] dst_src,
  output logic [NDST*DW-1:0]  dst_data
);
  logic [NSRC-1:0]    q_full  [NDST];
  logic [NSRC-1:0]    q_empty [NDST];
  logic [NSRC-1:0]    q_pop   [NDST];
  logic [NSRC*DW-1:0] q_head  [NDST];

  for (genvar d = 0; d < NDST; d++) begin : g_dst
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic push;
      assign push = src_valid[s] && (src_dst[s*DIW +: DIW] == DIW'(d)) && !q_full[d][s];

      xbar_pair_q #(.DW(DW)) u_q (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (src_data[s*DW +: DW]),
        .pop       (q_pop[d][s]),
        .head      (q_head[d][s*DW +: DW]),
        .empty     (q_empty[d][s]),
        .full      (q_full[d][s])
      );
    end

    xbar_dst_port #(.NSRC(NSRC), .DW(DW)) u_port (
      .clk       (clk),
      .rst       (rst),
      .req       (~q_empty[d]),
      .heads     (q_head[d]),
      .pop       (q_pop[d]),
      .out_valid (dst_valid[d]),
      .out_src   (dst_src[d*SIW +: SIW]),
      .out_data  (dst_data[d*DW +: DW])
    );
  end

  // Credit back to each source for the pair its index names.
  always_comb begin
    src_ready = '0;
    for (int s = 0; s < NSRC; s++) begin
      for (int d = 0; d < NDST; d++) begin
        if (src_dst[s*DIW +: DIW] == DIW'(d)) src_ready[s] = !q_full[d][s];
      end
    end
  end
endmodule

// File: rtl/req_xbar_chk.sv
module req_xbar_chk #(
  parameter int NSRC = 8,
  parameter int NDST = 9,
  localparam int DIW = (NDST > 1) ? $clog2(NDST) : 1,
  localparam int SIW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic [NSRC-1:0]     src_valid,
  input logic [NSRC-1:0]     src_ready,
  input logic [NSRC*DIW-1:0] src_dst,
  input logic [NDST-1:0]     dst_valid,
  input logic [NDST*SIW-1:0] dst_src
);
  // Packets per pair taken but not yet seen at the outputs.
  logic [2:0] inflight [NSRC][NDST];
  logic       took     [NSRC][NDST];
  logic       left     [NSRC][NDST];
  logic       too_many, ghost, bad_take;

  always_comb begin
    too_many = 1'b0;
    ghost    = 1'b0;
    bad_take = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_valid[s] && src_ready[s] && int'(src_dst[s*DIW +: DIW]) >= NDST) bad_take = 1'b1;
      for (int d = 0; d < NDST; d++) begin
        took[s][d] = src_valid[s] && src_ready[s] && (int'(src_dst[s*DIW +: DIW]) == d);
        left[s][d] = dst_valid[d] && (int'(dst_src[d*SIW +: SIW]) == s);
        if (inflight[s][d] > 3'd5) too_many = 1'b1;
        if (left[s][d] && inflight[s][d] == 3'd0) ghost = 1'b1;
      end
    end
    for (int d = 0; d < NDST; d++) begin
      if (dst_valid[d] && int'(dst_src[d*SIW +: SIW]) >= NSRC) ghost = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSRC; s++) begin
      for (int d = 0; d < NDST; d++) begin
        if (rst) inflight[s][d] <= 3'd0;
        else     inflight[s][d] <= inflight[s][d] + {2'b0, took[s][d]} - {2'b0, left[s][d]};
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dst_valid == '0))
    else $error("outputs active right after reset");

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst) !too_many)
    else $error("pair holds more than queue plus pipeline");

  assert_no_ghost_R5: assert property (@(posedge clk) disable iff (rst) !ghost)
    else $error("output without a matching accepted packet");

  assert_bad_index_R7: assert property (@(posedge clk) disable iff (rst) !bad_take)
    else $error("out-of-range destination accepted");
endmodule

bind req_xbar req_xbar_chk #(.NSRC(NSRC), .NDST(NDST)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_valid (src_valid),
  .src_ready (src_ready),
  .src_dst   (src_dst),
  .dst_valid (dst_valid),
  .dst_src   (dst_src)
);

// File: tb/req_xbar_tb.sv
module req_xbar_tb;
  localparam int NS  = 8;
  localparam int ND  = 9;
  localparam int DW  = 16;
  localparam int DIW = 4;
  localparam int SIW = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NS-1:0]     src_valid = '0;
  logic [NS-1:0]     src_ready;
  logic [NS*DIW-1:0] src_dst = '0;
  logic [NS*DW-1:0]  src_data = '0;
  logic [ND-1:0]     dst_valid;
  logic [ND*SIW-1:0] dst_src;
  logic [ND*DW-1:0]  dst_data;

  always #10 clk = ~clk;

  req_xbar #(.NSRC(NS), .NDST(ND), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_ready(src_ready),
    .src_dst(src_dst), .src_data(src_data), .dst_valid(dst_valid),
    .dst_src(dst_src), .dst_data(dst_data)
  );

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] expq [NS*ND][$];
  logic          w_v   [NS];
  int            w_d   [NS];
  logic [DW-1:0] w_data[NS];
  int            seq   [NS];
  logic          acc   [NS];
  logic          rdy   [NS];
  int            mon_s;
  logic [DW-1:0] mon_e;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mk(input int s, input int d);
    w_v[s]    = 1'b1;
    w_d[s]    = d;
    w_data[s] = {4'(s), 4'(d), 8'(seq[s])};
    seq[s]++;
  endtask

  // Present offers, note which are taken, advance to the next falling edge.
  task automatic cycle();
    for (int s = 0; s < NS; s++) begin
      src_valid[s] = w_v[s];
      src_dst[s*DIW +: DIW] = DIW'(w_d[s]);
      src_data[s*DW +: DW]  = w_data[s];
    end
    #1;
    for (int s = 0; s < NS; s++) begin
      rdy[s] = src_ready[s];
      acc[s] = w_v[s] && src_ready[s];
      if (acc[s]) expq[s*ND + w_d[s]].push_back(w_data[s]);
    end
    @(negedge clk);
  endtask

  task automatic clear_offers();
    for (int s = 0; s < NS; s++) begin
      w_v[s] = 1'b0; w_d[s] = 0; w_data[s] = '0; acc[s] = 1'b0; rdy[s] = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    clear_offers();
    src_valid = '0;
    for (int k = 0; k < NS*ND; k++) expq[k].delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Scoreboard: each output must match the oldest outstanding packet of its pair.
  always @(negedge clk) begin
    if (!rst) begin
      for (int d = 0; d < ND; d++) begin
        if (dst_valid[d]) begin
          mon_s = int'(dst_src[d*SIW +: SIW]);
          if (expq[mon_s*ND + d].size() == 0) begin
            check(1'b0, "R3 packet with nothing outstanding on pair", mon_s*ND + d, -1);
          end else begin
            mon_e = expq[mon_s*ND + d].pop_front();
            check(dst_data[d*DW +: DW] == mon_e, "R9 per-pair order and data",
                  dst_data[d*DW +: DW], mon_e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 150000, 0);
    report();
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) seq[s] = 0;
    do_reset();

    // R1: quiet outputs and free credits after reset.
    #1;
    check(dst_valid == '0, "R1 dst_valid after reset", dst_valid, 0);
    check(src_ready == '1, "R1 src_ready after reset", src_ready, 255);
    @(negedge clk);

    // R1/R8: pointer starts at source 0 -> s1 beats s7 on dst 0.
    mk(7, 0); mk(1, 0);
    cycle();
    clear_offers();
    cycle(); cycle(); cycle();
    check(dst_valid[0] && dst_src[0 +: SIW] == 3'd1, "R1 first grant to lowest source", dst_src[0 +: SIW], 1);
    cycle();
    check(dst_valid[0] && dst_src[0 +: SIW] == 3'd7, "R8 second grant", dst_src[0 +: SIW], 7);
    repeat (4) cycle();

    // R8: pointer moves past the winner and wraps.
    mk(5, 5); cycle(); clear_offers(); repeat (6) cycle();
    mk(2, 5); mk(6, 5); cycle(); clear_offers(); repeat (3) cycle();
    check(dst_src[5*SIW +: SIW] == 3'd6, "R8 winner after pointer moved to 6", dst_src[5*SIW +: SIW], 6);
    cycle();
    check(dst_src[5*SIW +: SIW] == 3'd2, "R8 next winner", dst_src[5*SIW +: SIW], 2);
    repeat (4) cycle();
    mk(1, 5); mk(2, 5); cycle(); clear_offers(); repeat (3) cycle();
    check(dst_src[5*SIW +: SIW] == 3'd1, "R8 wrap from pointer 3", dst_src[5*SIW +: SIW], 1);
    repeat (5) cycle();

    // R7: indices 9..15 are refused and produce nothing.
    for (int k = 0; k < 2; k++) begin
      for (int s = 0; s < NS; s++) begin
        w_v[s] = 1'b1; w_d[s] = 9 + ((s + k*4) % 7); w_data[s] = 16'hdead;
      end
      begin
        int quiet;
        int refused;
        quiet = 0; refused = 0;
        for (int c = 0; c < 6; c++) begin
          cycle();
          for (int s = 0; s < NS; s++) if (!rdy[s]) refused++;
          if (dst_valid == '0) quiet++;
        end
        check(refused == 6*NS, "R7 out-of-range index refused", refused, 6*NS);
        check(quiet == 6, "R7 no output for refused offers", quiet, 6);
      end
    end
    clear_offers();
    cycle();

    // R4/R5: every pair, one packet alone, exact latency and routing.
    begin
      int lat_bad;
      int route_bad;
      lat_bad = 0; route_bad = 0;
      for (int s = 0; s < NS; s++) begin
        for (int d = 0; d < ND; d++) begin
          mk(s, d);
          cycle();
          if (!acc[s]) lat_bad++;
          clear_offers();
          cycle(); if (dst_valid != '0) lat_bad++;
          cycle(); if (dst_valid != '0) lat_bad++;
          cycle();
          if (dst_valid != ND'(1 << d)) lat_bad++;
          if (int'(dst_src[d*SIW +: SIW]) != s) route_bad++;
          if (dst_data[d*DW +: DW] != {4'(s), 4'(d), 8'(seq[s] - 1)}) route_bad++;
          cycle(); if (dst_valid != '0) lat_bad++;
        end
      end
      check(lat_bad == 0, "R4 uncontended latency over all pairs", lat_bad, 0);
      check(route_bad == 0, "R5 routing over all pairs", route_bad, 0);
    end

    // R6: eight disjoint full-rate streams run together.
    begin
      int all8;
      all8 = 0;
      for (int s = 0; s < NS; s++) mk(s, s);
      for (int c = 0; c < 24; c++) begin
        cycle();
        for (int s = 0; s < NS; s++) if (acc[s]) mk(s, s);
        if ($countones(dst_valid[NS-1:0]) == NS) all8++;
      end
      check(all8 == 21, "R6 cycles with eight destinations active", all8, 21);
      clear_offers();
      repeat (8) cycle();
    end

    // R2/R3/R8: all sources saturate dst 3 from a fresh reset.
    do_reset();
    begin
      int first_at;
      int prev;
      int rr_err;
      int s7_taken;
      bit s7_low_at2;
      first_at = -1; prev = 0; rr_err = 0; s7_taken = 0; s7_low_at2 = 0;
      for (int s = 0; s < NS; s++) mk(s, 3);
      for (int c = 0; c < 64; c++) begin
        cycle();
        if (c < 9 && acc[7]) s7_taken++;
        if (c == 2) s7_low_at2 = !rdy[7];
        if (c == 9 && !acc[7]) rr_err++;
        for (int s = 0; s < NS; s++) if (acc[s]) mk(s, 3);
        if (first_at < 0) begin
          if (dst_valid[3]) begin
            first_at = c;
            prev = int'(dst_src[3*SIW +: SIW]);
            if (prev != 0) rr_err++;
          end
        end else begin
          if (!dst_valid[3] || int'(dst_src[3*SIW +: SIW]) != (prev + 1) % NS) rr_err++;
          prev = int'(dst_src[3*SIW +: SIW]);
        end
      end
      check(first_at == 3, "R4 first saturated output cycle", first_at, 3);
      check(rr_err == 0, "R8 round-robin rotation under saturation", rr_err, 0);
      check(s7_low_at2, "R2 credit drops with two queued", rdy[7], 0);
      check(s7_taken == 2, "R3 pair queue depth is two", s7_taken, 2);
      clear_offers();
      repeat (12) cycle();
    end

    // R3/R9: mixed traffic with gaps and varied destinations, then drain.
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 80; c++) begin
        for (int s = 0; s < NS; s++)
          if (!w_v[s] && ((c + s + p) % 3) != 0) mk(s, (s + seq[s]*(p + 2) + p) % ND);
        cycle();
        for (int s = 0; s < NS; s++) if (acc[s]) w_v[s] = 1'b0;
      end
      clear_offers();
      repeat (16) cycle();
      begin
        int left;
        left = 0;
        for (int k = 0; k < NS*ND; k++) left += expq[k].size();
        check(left == 0, "R3 every taken packet delivered once", left, 0);
      end
    end

    report();
    $finish;
  end
endmodule